// File: doc/BRIEF.md
# System Reset Controller with Pulse Stretcher

This block merges every reset request of a chip into one system reset. The internal requests come from two watchdogs, software, power events and low-power entry. Any of them starts a pulse that lasts a programmed minimum number of reference-clock cycles, even when the request is a single cycle long. While such a pulse is active the block pulls the shared open-drain reset pin low. The pin is read back through a synchronizer and a glitch filter, and an external device holding the pin low keeps the system in reset for exactly as long as it holds it, with no added stretch.

Power events (power-on or power-down detection, brownout, leaving Standby) also drive a separate power-reset output, which clears everything except the backup domain. The backup domain has its own reset request and output, and these touch nothing else. Two configuration bits select, for Stop entry and Standby entry separately, whether a completed entry sequence goes into the low-power mode or becomes a reset. A sticky set of cause flags records which sources caused resets. A power event leaves only the power flag set, and a clear input wipes all flags.

Top module: `sys_reset_ctrl`

## Requirements
- R1: A one-cycle request on the window watchdog, independent watchdog or software input raises sys_rst_o from the next clock edge for exactly MIN_PULSE_CYCLES cycles, and pin_drive_no is low during those same cycles.
- R2: A new internal request during an active pulse restarts the count, so the pulse ends MIN_PULSE_CYCLES cycles after the last request (a second request 5 cycles after the first gives 5 + MIN_PULSE_CYCLES cycles).
- R3: A one-cycle request on power detection, brownout or Standby exit raises both pwr_rst_o and sys_rst_o for exactly MIN_PULSE_CYCLES cycles.
- R4: With stop_keep_i high, a completed Stop entry sequence raises stop_enter_o in the same cycle and causes no reset. With stop_keep_i low, it raises no stop_enter_o and gives a MIN_PULSE_CYCLES reset.
- R5: With stby_keep_i high, a completed Standby entry sequence raises stby_enter_o in the same cycle and causes no reset. With stby_keep_i low, it raises no stby_enter_o and gives a MIN_PULSE_CYCLES reset.
- R6: An external low on the pin lasting L clock edges, with L at least FILT_CYCLES, holds sys_rst_o high for exactly L cycles, after a fixed latency of FILT_CYCLES+2 edges. The block does not drive the pin and does not raise pwr_rst_o for it.
- R7: An external low lasting fewer than FILT_CYCLES edges is ignored: sys_rst_o stays low and the pin cause flag stays clear.
- R8: The block's own pin drive, read back, is not taken as an external reset. An internal pulse is not lengthened and does not set the pin cause flag.
- R9: pwr_rst_o stays low for watchdog, software, low-power and pin resets.
- R10: A one-cycle bkp_rst_req_i raises bkp_rst_o for one cycle after the next edge, with sys_rst_o and pwr_rst_o low. Power events never raise bkp_rst_o.
- R11: cause_o bits are 0 pin, 1 power, 2 software, 3 independent watchdog, 4 window watchdog, 5 low-power. A bit is set from the edge after its source fires and stays set while later sources add their own bits.
- R12: A power event leaves cause_o with only bit 1 set. cause_clr_i clears all bits at the next edge, but a source active in the same cycle still sets its bit.
- R13: Right after rst_ni is released, sys_rst_o, pwr_rst_o, bkp_rst_o and cause_o are zero and pin_drive_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the controller's own registers |
| pin_i | input | 1 | Reset pin level read back (low = reset) |
| pin_drive_no | output | 1 | Active-low enable of the open-drain pin pull-down |
| wwdg_req_i | input | 1 | Window watchdog reset request |
| iwdg_req_i | input | 1 | Independent watchdog reset request |
| sw_req_i | input | 1 | Software reset request |
| pwr_det_req_i | input | 1 | Power-on / power-down detection event |
| bor_req_i | input | 1 | Brownout detection event |
| stby_exit_i | input | 1 | Exit from Standby mode |
| stop_seq_done_i | input | 1 | Stop entry sequence completed |
| stby_seq_done_i | input | 1 | Standby entry sequence completed |
| stop_keep_i | input | 1 | 1: Stop entry proceeds, 0: converts to reset |
| stby_keep_i | input | 1 | 1: Standby entry proceeds, 0: converts to reset |
| bkp_rst_req_i | input | 1 | Backup-domain reset request |
| cause_clr_i | input | 1 | Clears all cause flags |
| sys_rst_o | output | 1 | System reset, active high |
| pwr_rst_o | output | 1 | Power reset (all but the backup domain), active high |
| bkp_rst_o | output | 1 | Backup-domain reset, active high |
| stop_enter_o | output | 1 | Grant to enter Stop mode |
| stby_enter_o | output | 1 | Grant to enter Standby mode |
| cause_o | output | 6 | Sticky reset-cause flags |

## Verification
Single-cycle requests on each internal source, with the pin looped back as open drain, show that the pulse length is set by the counter and not by the request. They also show that the block's own pin drive does not lengthen the pulse or pass for an external reset. A second request inside a pulse tells a reloading counter apart from one that only runs down. External lows just above and just below the filter length tell pass-through of the true duration apart from glitch rejection. Low-power entry with each option value, power events against other sources, and backup requests in isolation separate the three reset outputs and the mode grants.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
    localparam int CAUSE_W    = 6;
    localparam int CAUSE_PIN  = 0;
    localparam int CAUSE_PWR  = 1;
    localparam int CAUSE_SW   = 2;
    localparam int CAUSE_IWDG = 3;
    localparam int CAUSE_WWDG = 4;
    localparam int CAUSE_LPWR = 5;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t PWR_ONLY = cause_t'(1) << CAUSE_PWR;
endpackage

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int MIN_CYCLES = 640
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic active_o
);
    localparam int CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(MIN_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    // Reload on every request, otherwise count down to zero
    always_comb begin
        s_d = s_q;
        if (req_i) begin
            s_d.cnt = LOAD;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign active_o = (s_q.cnt != '0);

    assert_req_starts_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> active_o);
    assert_end_without_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(active_o) |-> !$past(req_i));
    assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= LOAD);
endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic level_o,
    output logic sync_o
);
    localparam int FCW = $clog2(FILT_CYCLES + 1);
    localparam logic [FCW-1:0] LAST = FCW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   level;
        logic [FCW-1:0]         cnt;
    } st_t;

    st_t  s_d, s_q;
    logic sync_out;

    assign sync_out = s_q.sync[SYNC_STAGES-1];

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], pin_i};
        if (sync_out == s_q.level) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == LAST) begin
            s_d.level = sync_out;
            s_d.cnt   = '0;
        end else begin
            s_d.cnt = s_q.cnt + FCW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{sync: '1, level: 1'b1, cnt: '0};
        else         s_q <= s_d;
    end

    assign level_o = s_q.level;
    assign sync_o  = sync_out;

    assert_level_from_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(s_q.level) |-> (s_q.level == $past(sync_out)));
    assert_filt_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= LAST);
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
    import rst_ctrl_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  cause_t set_i,
    input  logic   clr_i,
    input  logic   pwr_i,
    output cause_t flags_o
);
    typedef struct packed {
        cause_t flags;
    } st_t;

    st_t s_d, s_q;

    // Clear (or power event) first, then the sources of this cycle set their bits
    always_comb begin
        s_d = s_q;
        if (clr_i || pwr_i) s_d.flags = '0;
        s_d.flags = s_d.flags | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign flags_o = s_q.flags;

    assert_pwr_leaves_one_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i == PWR_ONLY) |=> (flags_o == PWR_ONLY));
    assert_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !pwr_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/sys_reset_ctrl.sv
module sys_reset_ctrl
    import rst_ctrl_pkg::*;
#(
    parameter int MIN_PULSE_CYCLES = 640,
    parameter int FILT_CYCLES      = 4,
    parameter int SYNC_STAGES      = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pin_i,
    output logic               pin_drive_no,
    input  logic               wwdg_req_i,
    input  logic               iwdg_req_i,
    input  logic               sw_req_i,
    input  logic               pwr_det_req_i,
    input  logic               bor_req_i,
    input  logic               stby_exit_i,
    input  logic               stop_seq_done_i,
    input  logic               stby_seq_done_i,
    input  logic               stop_keep_i,
    input  logic               stby_keep_i,
    input  logic               bkp_rst_req_i,
    input  logic               cause_clr_i,
    output logic               sys_rst_o,
    output logic               pwr_rst_o,
    output logic               bkp_rst_o,
    output logic               stop_enter_o,
    output logic               stby_enter_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int NUM_STRETCH = 2;
    localparam int STR_SYS     = 0;
    localparam int STR_PWR     = 1;

    typedef struct packed {
        logic self_hold;
        logic bkp;
    } st_t;

    st_t    s_d, s_q;
    logic   lp_req, pwr_req, sys_req;
    logic   filt_level, filt_sync, ext_valid;
    logic [NUM_STRETCH-1:0] str_req, str_act;
    cause_t cause_set;

    // Source combining
    assign lp_req  = (stop_seq_done_i & ~stop_keep_i) | (stby_seq_done_i & ~stby_keep_i);
    assign pwr_req = pwr_det_req_i | bor_req_i | stby_exit_i;
    assign sys_req = wwdg_req_i | iwdg_req_i | sw_req_i | lp_req | pwr_req;

    assign stop_enter_o = stop_seq_done_i & stop_keep_i;
    assign stby_enter_o = stby_seq_done_i & stby_keep_i;

    assign str_req[STR_SYS] = sys_req;
    assign str_req[STR_PWR] = pwr_req;

    for (genvar g = 0; g < NUM_STRETCH; g++) begin : g_str
        rst_stretch #(.MIN_CYCLES(MIN_PULSE_CYCLES)) u_str (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .req_i    (str_req[g]),
            .active_o (str_act[g])
        );
    end

    rst_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i),
        .level_o (filt_level),
        .sync_o  (filt_sync)
    );

    // Self-hold masks the readback of our own drive until the pin is seen high again
    always_comb begin
        s_d           = s_q;
        s_d.self_hold = str_act[STR_SYS] | (s_q.self_hold & ~(filt_sync & filt_level));
        s_d.bkp       = bkp_rst_req_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ext_valid    = ~filt_level & ~s_q.self_hold;
    assign sys_rst_o    = str_act[STR_SYS] | ext_valid;
    assign pwr_rst_o    = str_act[STR_PWR];
    assign pin_drive_no = ~str_act[STR_SYS];
    assign bkp_rst_o    = s_q.bkp;

    always_comb begin
        cause_set             = '0;
        cause_set[CAUSE_PIN]  = ext_valid;
        cause_set[CAUSE_PWR]  = pwr_req;
        cause_set[CAUSE_SW]   = sw_req_i;
        cause_set[CAUSE_IWDG] = iwdg_req_i;
        cause_set[CAUSE_WWDG] = wwdg_req_i;
        cause_set[CAUSE_LPWR] = lp_req;
    end

    rst_cause_flags u_flags (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (cause_set),
        .clr_i   (cause_clr_i),
        .pwr_i   (pwr_req),
        .flags_o (cause_o)
    );

    assert_wdg_sw_drive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wwdg_req_i || iwdg_req_i || sw_req_i) |=> (sys_rst_o && !pin_drive_no));
    assert_pwr_in_sys_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_rst_o |-> sys_rst_o);
    assert_pwr_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwr_rst_o) |-> $past(pwr_det_req_i || bor_req_i || stby_exit_i));
    assert_stop_to_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_seq_done_i && !stop_keep_i) |=> sys_rst_o);
    assert_stby_to_reset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stby_seq_done_i && !stby_keep_i) |=> sys_rst_o);
    assert_bkp_isolated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bkp_rst_req_i |=> !bkp_rst_o);
    assert_own_drive_not_pin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pin_drive_no |=> !cause_o[CAUSE_PIN] || $past(cause_o[CAUSE_PIN]));
endmodule

// File: tb/tb_sys_reset_ctrl.sv
module tb_sys_reset_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MINC = 12;
    localparam int FILT = 4;
    localparam int WIN  = MINC + FILT + 25;
    // cause bit positions as given in R11
    localparam int B_PIN = 0, B_PWR = 1, B_SW = 2, B_IWDG = 3, B_WWDG = 4, B_LPWR = 5;

    logic clk = 1'b0, rst_n = 1'b0, ext_low = 1'b0;
    logic pin, pin_drive_no;
    logic wwdg = 0, iwdg = 0, sw = 0, pdet = 0, bor = 0, sexit = 0;
    logic stop_done = 0, stby_done = 0, stop_keep = 1, stby_keep = 1, bkp_req = 0, clr = 0;
    logic sys_rst, pwr_rst, bkp_rst, stop_en, stby_en;
    logic [5:0] cause;
    int errors = 0, checks = 0;
    int m_sys, m_pwr, m_drv, m_bkp;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign pin = !(ext_low || !pin_drive_no);

    sys_reset_ctrl #(.MIN_PULSE_CYCLES(MINC), .FILT_CYCLES(FILT)) dut (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .pin_drive_no(pin_drive_no),
        .wwdg_req_i(wwdg), .iwdg_req_i(iwdg), .sw_req_i(sw), .pwr_det_req_i(pdet),
        .bor_req_i(bor), .stby_exit_i(sexit), .stop_seq_done_i(stop_done),
        .stby_seq_done_i(stby_done), .stop_keep_i(stop_keep), .stby_keep_i(stby_keep),
        .bkp_rst_req_i(bkp_req), .cause_clr_i(clr), .sys_rst_o(sys_rst),
        .pwr_rst_o(pwr_rst), .bkp_rst_o(bkp_rst), .stop_enter_o(stop_en),
        .stby_enter_o(stby_en), .cause_o(cause));

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic drive(input int which, input logic v);
        case (which)
            0: wwdg = v;      1: iwdg = v;      2: sw = v;
            3: pdet = v;      4: bor = v;       5: sexit = v;
            6: stop_done = v; 7: stby_done = v; 8: bkp_req = v;
            default: ;
        endcase
    endtask

    // request at loop step 0 and optionally at step 'second'; counts output cycles
    task automatic run_src(input int which, input int second);
        m_sys = 0; m_pwr = 0; m_drv = 0; m_bkp = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            m_sys += int'(sys_rst); m_pwr += int'(pwr_rst);
            m_drv += int'(!pin_drive_no); m_bkp += int'(bkp_rst);
            drive(which, (i == 0) || (i == second));
        end
        repeat (FILT + 6) @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 sys_rst", sys_rst, 0);
        chk("R13 pwr_rst", pwr_rst, 0);
        chk("R13 bkp_rst", bkp_rst, 0);
        chk("R13 pin_drive_no", pin_drive_no, 1);
        chk("R13 cause", cause, 0);
    endtask

    task automatic t_internal();
        for (int s = 0; s < 3; s++) begin
            clear_flags();
            run_src(s, -1);
            chk("R1 pulse width", m_sys, MINC);
            chk("R1 pin drive width", m_drv, MINC);
            chk("R9 no power reset", m_pwr, 0);
            chk("R8 pin flag from own drive", cause[B_PIN], 0);
            chk("R11 cause bit", cause, (s == 0) ? (1 << B_WWDG) :
                                        (s == 1) ? (1 << B_IWDG) : (1 << B_SW));
        end
    endtask

    task automatic t_reload();
        run_src(2, 5);
        chk("R2 reload width", m_sys, MINC + 5);
    endtask

    task automatic t_power();
        for (int s = 3; s < 6; s++) begin
            clear_flags();
            run_src(s, -1);
            chk("R3 sys width", m_sys, MINC);
            chk("R3 pwr width", m_pwr, MINC);
            chk("R10 no bkp on power", m_bkp, 0);
            chk("R12 power only flag", cause, 1 << B_PWR);
        end
    endtask

    task automatic t_lowpower(input int which);
        string rq = (which == 6) ? "R4" : "R5";
        clear_flags();
        stop_keep = 1'b1; stby_keep = 1'b1;
        @(negedge clk); drive(which, 1'b1);
        #1;
        chk({rq, " grant when kept"}, (which == 6) ? stop_en : stby_en, 1);
        @(negedge clk); drive(which, 1'b0);
        run_src(99, -1);
        chk({rq, " no reset when kept"}, m_sys, 0);
        if (which == 6) stop_keep = 1'b0; else stby_keep = 1'b0;
        @(negedge clk); drive(which, 1'b1);
        #1;
        chk({rq, " no grant when converted"}, (which == 6) ? stop_en : stby_en, 0);
        @(negedge clk); drive(which, 1'b0);
        // request was sampled at the previous edge: one reset cycle already passed
        run_src(99, -1);
        chk({rq, " converted reset width"}, m_sys + 1, MINC);
        chk("R9 no power on low-power", m_pwr, 0);
        chk("R11 low-power flag", cause, 1 << B_LPWR);
        stop_keep = 1'b1; stby_keep = 1'b1;
    endtask

    task automatic t_pin(input int len);
        int ns = 0, nd = 0, np = 0;
        clear_flags();
        for (int i = 0; i < len + FILT + 12; i++) begin
            @(negedge clk);
            ns += int'(sys_rst); nd += int'(!pin_drive_no); np += int'(pwr_rst);
            ext_low = (i < len);
        end
        repeat (4) @(negedge clk);
        if (len >= FILT) begin
            chk("R6 external duration", ns, len);
            chk("R6 no drive for external", nd, 0);
            chk("R9 no power on pin", np, 0);
            chk("R11 pin flag", cause, 1 << B_PIN);
        end else begin
            chk("R7 glitch ignored", ns, 0);
            chk("R7 glitch no flag", cause, 0);
        end
    endtask

    task automatic t_backup();
        run_src(8, -1);
        chk("R10 bkp width", m_bkp, 1);
        chk("R10 no sys on bkp", m_sys, 0);
        chk("R10 no pwr on bkp", m_pwr, 0);
    endtask

    task automatic t_flags();
        clear_flags();
        run_src(2, -1);
        run_src(1, -1);
        chk("R11 sticky accumulate", cause, (1 << B_SW) | (1 << B_IWDG));
        run_src(4, -1);
        chk("R12 power clears others", cause, 1 << B_PWR);
        @(negedge clk); clr = 1'b1; sw = 1'b1;
        @(negedge clk); clr = 1'b0; sw = 1'b0;
        chk("R12 set beats clear", cause, 1 << B_SW);
        repeat (WIN) @(negedge clk);
        clear_flags();
        @(negedge clk);
        chk("R12 clear", cause, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_internal();
        t_reload();
        t_power();
        t_lowpower(6);
        t_lowpower(7);
        t_pin(10);
        t_pin(FILT - 1);
        t_backup();
        t_flags();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule